// File: doc/BRIEF.md
# Column-Serial AES-128 Encryption Core

This core encrypts a single 128-bit block with a 128-bit key using AES-128. It keeps the datapath narrow. Each cycle it handles one 32-bit column, which passes through four byte substitution units, a column-mixing stage and a round-key XOR. The result is written into a two-bank 128-bit state store. The row rotation of each round costs no logic of its own. Each of the four bytes that feed the substitution units is picked by a per-row multiplexer, which reads from the column offset by that row's index.

The expanded key schedule sits in an internal word memory. It is filled one word per cycle whenever a block arrives with a key that differs from the stored one. A block that arrives with the same key goes straight into the rounds and reuses the stored schedule. The pre-round XOR of plaintext and key happens in the cycle that accepts the start strobe.

Each round takes five cycles: four column reads and one drain slot of the two-stage column pipeline. The first round reads bank 0 and writes bank 1, the second reads bank 1 and writes bank 0, and so on. A round therefore never overwrites bytes that the round in progress still has to read.

Top module: `aes128_colserial`

## Requirements
- R1: For a given key and plaintext, `cipher` equals the AES-128 encryption of the plaintext under that key (for example key 000102..0f, plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a).
- R2: Byte order is big-endian across the vector. Bits [127:120] of `plain`, `key` and `cipher` carry byte 0 of the block, which is row 0 of column 0, and bytes fill columns top to bottom.
- R3: `done` is high for exactly one clock cycle per encrypted block.
- R4: When the key differs from the stored schedule, or no schedule exists yet, `done` goes high after the 91st rising edge following the edge that samples `start`. This covers 40 key-expansion cycles, one hand-over cycle and ten 5-cycle rounds.
- R5: When the key equals the key of the stored schedule, the stored round keys are reused and `done` goes high after the 50th rising edge following the edge that samples `start`.
- R6: A `start` pulse that arrives while a block is in progress has no effect on the running block's result or on its timing.
- R7: While `rst_n` is low, `done` is 0 and `cipher` is all zeros.
- R8: `cipher` keeps its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one block; sampled only when idle |
| plain | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| key | input | 128 | Cipher key, byte 0 in bits [127:120] |
| cipher | output | 128 | Ciphertext, valid when done is high and held afterwards |
| done | output | 1 | One-cycle pulse when cipher is updated |

## Verification
The hardest condition to reach from the ports is schedule reuse. It depends on hidden state: the key memory decides whether a block pays for expansion. The stimulus therefore runs a stream of blocks under one key, then changes the key, then returns to a stored key, and checks both the ciphertext and the exact start-to-done cycle count for each block. A second hard case is a start pulse that lands in the middle of a block. The bench raises `start` with a different plaintext and key several cycles into a run and confirms that neither the ciphertext nor the latency of the running block changes.

// File: rtl/aes_pkg.sv
package aes_pkg;

  localparam int NCOL     = 4;
  localparam int NROUND   = 10;
  localparam int NKW      = NCOL * (NROUND + 1);
  localparam int KW_BITS  = $clog2(NKW);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXPAND,
    ST_ROUND
  } enc_state_e;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // substitution: field inverse as b^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] b);
    logic [7:0] pw;
    logic [7:0] inv;
    pw  = b;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      pw  = gmul(pw, pw);
      inv = gmul(inv, pw);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_sbox_word.sv
module aes_sbox_word
  import aes_pkg::*;
(
  input  logic [31:0] din,
  output logic [31:0] dout
);
  for (genvar g = 0; g < NCOL; g++) begin : g_byte
    assign dout[8*g +: 8] = sbox(din[8*g +: 8]);
  end
endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol
  import aes_pkg::*;
(
  input  logic [31:0] din,
  output logic [31:0] dout
);
  logic [7:0] a0, a1, a2, a3;
  assign {a0, a1, a2, a3} = din;

  assign dout[31:24] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
  assign dout[23:16] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
  assign dout[15:8]  = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
  assign dout[7:0]   = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
endmodule

// File: rtl/aes_key_store.sv
module aes_key_store
  import aes_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [127:0]       key,
  input  logic [KW_BITS-1:0] rd_idx,
  output logic [31:0]        rd_word,
  output logic               ready,
  output logic               match
);
  localparam logic [KW_BITS-1:0] LAST_IDX  = KW_BITS'(NKW - 1);
  localparam logic [KW_BITS-1:0] FIRST_GEN = KW_BITS'(NCOL);

  logic [31:0]        kmem [NKW];
  logic [KW_BITS-1:0] idx, idx_n;
  logic [7:0]         rcon, rcon_n;
  logic               busy, busy_n;
  logic               valid, valid_n;

  logic [31:0] w_prev, w_back, w_rot, w_sub, w_new;
  logic        word_first;

  assign w_prev     = kmem[idx - KW_BITS'(1)];
  assign w_back     = kmem[idx - KW_BITS'(NCOL)];
  assign w_rot      = {w_prev[23:0], w_prev[31:24]};
  assign word_first = (idx[1:0] == 2'b00);

  aes_sbox_word u_ksub (.din(w_rot), .dout(w_sub));

  assign w_new = w_back ^ (word_first ? (w_sub ^ {rcon, 24'h0}) : w_prev);

  always_comb begin
    idx_n   = idx;
    rcon_n  = rcon;
    busy_n  = busy;
    valid_n = valid;
    if (load) begin
      idx_n   = FIRST_GEN;
      rcon_n  = 8'h01;
      busy_n  = 1'b1;
      valid_n = 1'b0;
    end else if (busy) begin
      idx_n = idx + KW_BITS'(1);
      if (word_first) rcon_n = xtime(rcon);
      if (idx == LAST_IDX) begin
        busy_n  = 1'b0;
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      rcon  <= 8'h01;
      busy  <= 1'b0;
      valid <= 1'b0;
    end else begin
      idx   <= idx_n;
      rcon  <= rcon_n;
      busy  <= busy_n;
      valid <= valid_n;
    end
  end

  // schedule storage, no reset needed
  always_ff @(posedge clk) begin
    if (load) begin
      for (int c = 0; c < NCOL; c++) kmem[c] <= key[127-32*c -: 32];
    end else if (busy) begin
      kmem[idx] <= w_new;
    end
  end

  assign rd_word = kmem[rd_idx];
  assign ready   = valid;
  assign match   = valid && ({kmem[0], kmem[1], kmem[2], kmem[3]} == key);

  AST_NO_RELOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R6
  AST_KEYS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !load) |=> ($stable(kmem[0]) && $stable(kmem[NKW-1]))); // R5

endmodule

// File: rtl/aes128_colserial.sv
module aes128_colserial
  import aes_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] plain,
  input  logic [127:0] key,
  output logic [127:0] cipher,
  output logic         done
);
  localparam logic [3:0] LAST_RND = 4'(NROUND);
  localparam logic [2:0] DRAIN    = 3'(NCOL);

  enc_state_e state, state_n;
  logic [3:0] rnd, rnd_n;
  logic [2:0] cnt, cnt_n;

  logic [31:0] bank [2][NCOL];
  logic [31:0] p_word;
  logic [1:0]  p_col;
  logic        p_vld, p_vld_n;

  logic        kx_load, kx_ready, kx_match, pre_we, fin;
  logic [31:0] rk_word, mux_word, sb_word, mix_word, ark;
  logic        rd_b, wr_b;

  assign rd_b = ~rnd[0];
  assign wr_b = rnd[0];

  // per-row column select replaces a separate row-rotation stage
  for (genvar r = 0; r < NCOL; r++) begin : g_rowsel
    logic [1:0] src_col;
    assign src_col = cnt[1:0] + 2'(r);
    assign mux_word[31-8*r -: 8] = bank[rd_b][src_col][31-8*r -: 8];
  end

  aes_sbox_word u_sub (.din(mux_word), .dout(sb_word));
  aes_mixcol    u_mix (.din(p_word),   .dout(mix_word));

  aes_key_store u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (kx_load),
    .key     (key),
    .rd_idx  ({rnd, p_col}),
    .rd_word (rk_word),
    .ready   (kx_ready),
    .match   (kx_match)
  );

  assign ark = ((rnd == LAST_RND) ? p_word : mix_word) ^ rk_word;
  assign fin = (state == ST_ROUND) && (cnt == DRAIN) && (rnd == LAST_RND);

  always_comb begin
    state_n = state;
    rnd_n   = rnd;
    cnt_n   = cnt;
    kx_load = 1'b0;
    pre_we  = 1'b0;
    p_vld_n = (state == ST_ROUND) && (cnt < DRAIN);
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          pre_we = 1'b1;
          rnd_n  = 4'd1;
          cnt_n  = 3'd0;
          if (kx_match) begin
            state_n = ST_ROUND;
          end else begin
            kx_load = 1'b1;
            state_n = ST_EXPAND;
          end
        end
      end
      ST_EXPAND: begin
        if (kx_ready) state_n = ST_ROUND;
      end
      ST_ROUND: begin
        if (cnt == DRAIN) begin
          cnt_n = 3'd0;
          if (rnd == LAST_RND) state_n = ST_IDLE;
          else                 rnd_n   = rnd + 4'd1;
        end else begin
          cnt_n = cnt + 3'd1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rnd    <= 4'd0;
      cnt    <= 3'd0;
      p_vld  <= 1'b0;
      done   <= 1'b0;
      cipher <= '0;
    end else begin
      state <= state_n;
      rnd   <= rnd_n;
      cnt   <= cnt_n;
      p_vld <= p_vld_n;
      done  <= fin;
      if (fin) cipher <= {bank[0][0], bank[0][1], bank[0][2], ark};
    end
  end

  // datapath registers, enables written out, no reset
  always_ff @(posedge clk) begin
    if (p_vld_n) begin
      p_word <= sb_word;
      p_col  <= cnt[1:0];
    end
    if (pre_we) begin
      for (int c = 0; c < NCOL; c++)
        bank[0][c] <= plain[127-32*c -: 32] ^ key[127-32*c -: 32];
    end else if (p_vld) begin
      bank[wr_b][p_col] <= ark;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_CIPHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(cipher)); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(rnd) == LAST_RND)); // R4
  AST_PIPE_IN_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    p_vld |-> (state == ST_ROUND)); // R6

endmodule

// File: tb/aes128_colserial_test.sv
module aes128_colserial_test;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [127:0] plain;
  logic [127:0] key;
  logic [127:0] cipher;
  logic         done;

  int checks = 0;
  int fails  = 0;

  localparam int LAT_NEW  = 92; // done seen at negedge after edge 91 (R4)
  localparam int LAT_HIT  = 51; // done seen at negedge after edge 50 (R5)

  aes128_colserial uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .plain(plain), .key(key), .cipher(cipher), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one block; optionally raise a stray start at cycle poke_at
  task automatic enc(input logic [127:0] pt, input logic [127:0] k,
                     input int poke_at,
                     output logic [127:0] ct, output int lat, output bit one_pulse);
    @(negedge clk);
    plain = pt;
    key   = k;
    start = 1'b1;
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (lat == poke_at) begin
        start = 1'b1;
        plain = ~pt;
        key   = k ^ 128'h1;
      end
      if (lat == poke_at + 1) begin
        plain = pt;
        key   = k;
      end
      if (done || lat > 400) break;
    end
    ct = cipher;
    @(negedge clk);
    one_pulse = !done && (cipher == ct);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R7 done in reset", 128'(done), 128'h0);
    chk(cipher == '0, "R7 cipher in reset", cipher, 128'h0);
  endtask

  task automatic t_fips_vector;
    logic [127:0] ct; int lat; bit p;
    enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
        -1, ct, lat, p);
    chk(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 R2 standard vector", ct,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk(lat == LAT_NEW, "R4 latency new key", 128'(lat), 128'(LAT_NEW));
    chk(p, "R3 single-cycle done", 128'(p), 128'h1);
  endtask

  task automatic t_stream_reuse;
    logic [127:0] k;
    logic [127:0] pts [4];
    logic [127:0] cts [4];
    k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    pts[0] = 128'h6bc1bee22e409f96e93d7e117393172a; cts[0] = 128'h3ad77bb40d7a3660a89ecaf32466ef97;
    pts[1] = 128'hae2d8a571e03ac9c9eb76fac45af8e51; cts[1] = 128'hf5d3d58503b9699de785895a96fdbaaf;
    pts[2] = 128'h30c81c46a35ce411e5fbc1191a0a52ef; cts[2] = 128'h43b1cd7f598ece23881b00e3ed030688;
    pts[3] = 128'hf69f2445df4f9b17ad2b417be66c3710; cts[3] = 128'h7b0c785e27e8ad3f8223207104725dd4;
    for (int i = 0; i < 4; i++) begin
      logic [127:0] ct; int lat; bit p;
      enc(pts[i], k, -1, ct, lat, p);
      chk(ct == cts[i], "R1 stream block", ct, cts[i]);
      if (i == 0) chk(lat == LAT_NEW, "R4 first block new key", 128'(lat), 128'(LAT_NEW));
      else        chk(lat == LAT_HIT, "R5 stored keys reused", 128'(lat), 128'(LAT_HIT));
      chk(p, "R3 pulse in stream", 128'(p), 128'h1);
    end
  endtask

  task automatic t_busy_start;
    logic [127:0] ct; int lat; bit p;
    enc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
        12, ct, lat, p);
    chk(ct == 128'h3925841d02dc09fbdc118597196a0b32, "R6 start while busy result", ct,
        128'h3925841d02dc09fbdc118597196a0b32);
    chk(lat == LAT_HIT, "R6 start while busy timing", 128'(lat), 128'(LAT_HIT));
  endtask

  task automatic t_key_change;
    logic [127:0] ct; int lat; bit p;
    enc(128'h0, 128'h0, -1, ct, lat, p);
    chk(ct == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R1 zero key", ct,
        128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    chk(lat == LAT_NEW, "R4 key change re-expands", 128'(lat), 128'(LAT_NEW));
  endtask

  task automatic t_hold;
    logic [127:0] snap;
    snap = cipher;
    plain = ~plain;
    key   = ~key;
    repeat (20) @(negedge clk);
    chk(cipher == snap, "R8 cipher held while idle", cipher, snap);
    chk(done == 1'b0, "R3 no spurious done", 128'(done), 128'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    plain = '0;
    key   = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_fips_vector();
    t_stream_reuse();
    t_busy_start();
    t_key_change();
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule